// File: doc/BRIEF.md
# I2C Single-Master Byte Controller

This block is a command-driven controller for a two-wire bus that has exactly one master and devices with 7-bit addresses. Software, or a small sequencer, issues one operation at a time: a start condition, a stop condition, a byte write, a byte read, or an acknowledge bit. Each operation is a short, self-contained phase on the bus. When it ends, the block raises a one-cycle completion flag, and the caller then decides what to issue next. The address phase is an ordinary byte write: the 7-bit address followed by a direction bit (0 = write, 1 = read).

Both bus lines are open-drain. The block only ever asks for a line to be pulled low or released, and it senses the resolved SDA level through an input. The bit rate comes from an 8-bit reload value. A counter produces a quarter-bit tick every reload+1 clocks, and four ticks make one SCL period, so SCL runs at f_clk / (4 × (reload + 1)). After a byte write, the block samples the slave's response into an acknowledge-status output. After a byte read, the eight received bits appear on the read-data output, and the caller then sends ACK or NACK with a separate acknowledge command.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, both line-drive outputs are 0 (released), busy is 0, done and collision are 0, ack_status is 0 and rd_data is 0.
- R2: The block is busy from the cycle after a command is accepted until the completion cycle. Each quarter-bit phase lasts reload+1 clocks. A bit lasts four quarters. A start, stop or acknowledge command takes 1 bit, a read takes 8 bits and a write takes 9 bits.
- R3: Start: quarter 0 releases both lines, quarter 1 pulls SDA low with SCL released, and quarters 2–3 hold both lines low.
- R4: Write: bit k (k = 0..7) drives the complement of wr_data[7-k] on the SDA drive output (MSB first), with SCL driven low in quarters 0 and 3 and released in quarters 1 and 2. Bit 8 releases SDA. While SCL is released during a write, read or acknowledge, SDA does not change.
- R5: During bit 8 of a write, the resolved SDA level at the end of quarter 1 is captured on ack_status: 0 = ACK, 1 = NACK. The value holds until the next write.
- R6: Read: SDA is released for all 8 bits, and the bus level at the end of quarter 1 of each bit is shifted in MSB first. rd_data takes the full byte in the completion cycle.
- R7: Acknowledge: the ack_value latched when the command is accepted is sent as one bit. 0 pulls SDA low (ACK) and 1 releases it (NACK), with the same SCL pattern as R4.
- R8: Stop: quarter 0 holds both lines low, quarter 1 releases SCL, and quarters 2–3 release SDA too. At completion both lines are released.
- R9: done is a single-cycle pulse in the cycle after the last quarter ends, with busy already 0. Line levels hold between commands.
- R10: A cmd_write strobe while busy is ignored and gives a one-cycle collision pulse on the next cycle. Any other strobe while busy is also ignored, and the bus waveform is unchanged.
- R11: When several strobes are high together in idle, one is taken, in the priority start, stop, write, read, acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start-condition strobe |
| cmd_stop | input | 1 | Stop-condition strobe |
| cmd_write | input | 1 | Byte-write strobe (takes wr_data) |
| cmd_read | input | 1 | Byte-read strobe |
| cmd_ack | input | 1 | Acknowledge-bit strobe (takes ack_value) |
| wr_data | input | 8 | Byte to transmit |
| ack_value | input | 1 | Bit sent by the acknowledge command: 0 ACK, 1 NACK |
| reload | input | 8 | Quarter-bit divider reload value |
| sda_in | input | 1 | Resolved SDA level sensed from the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion flag |
| collision | output | 1 | One-cycle flag for a write strobe issued while busy |
| ack_status | output | 1 | Acknowledge bit sampled after the last write |
| rd_data | output | 8 | Last byte read |

## Verification
A wrong quarter index or a wrong divider count shows up at once as a line-drive output that differs from the reference waveform, within one quarter-bit period, because the bench compares both drive outputs on every clock. A shift register loaded with the wrong value or shifted at the wrong time shows up on SDA within the same bit during writes. During reads it shows up only at completion, as a wrong rd_data byte. A sample taken at the wrong time shows up at the end of the operation, as a wrong ack_status or rd_data. A command accepted while busy breaks the waveform comparison in the very next quarter.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4,
    OP_ACK   = 3'd5
  } op_e;

  typedef struct packed {
    logic scl_low;
    logic sda_low;
  } lines_t;

  // Bit slots per operation (R2)
  function automatic int op_bits(op_e op, int data_w);
    case (op)
      OP_WRITE: op_bits = data_w + 1;
      OP_READ:  op_bits = data_w;
      default:  op_bits = 1;
    endcase
  endfunction

  // Line levels for a quarter of the current bit (R3, R4, R8)
  function automatic lines_t quarter_lines(op_e op, logic [1:0] q, logic bit_low);
    lines_t l;
    case (op)
      OP_START: begin
        l.scl_low = (q >= 2'd2);
        l.sda_low = (q != 2'd0);
      end
      OP_STOP: begin
        l.scl_low = (q == 2'd0);
        l.sda_low = (q <= 2'd1);
      end
      default: begin
        l.scl_low = (q == 2'd0) || (q == 2'd3);
        l.sda_low = bit_low;
      end
    endcase
    return l;
  endfunction

endpackage

// File: rtl/i2cm_divider.sv
module i2cm_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cm_shreg.sv
module i2cm_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         shift_in,
  output logic [W-1:0] value,
  output logic         next_msb
);
  assign next_msb = value[W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (load)  value <= load_val;
    else if (shift) value <= {value[W-2:0], shift_in};
  end
endmodule

// File: rtl/i2cm_cmd_pick.sv
module i2cm_cmd_pick
  import i2cm_pkg::*;
(
  input  logic cmd_start,
  input  logic cmd_stop,
  input  logic cmd_write,
  input  logic cmd_read,
  input  logic cmd_ack,
  output op_e  sel
);
  // Fixed priority (R11)
  always_comb begin
    if (cmd_start)      sel = OP_START;
    else if (cmd_stop)  sel = OP_STOP;
    else if (cmd_write) sel = OP_WRITE;
    else if (cmd_read)  sel = OP_READ;
    else if (cmd_ack)   sel = OP_ACK;
    else                sel = OP_NONE;
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_write,
  input  logic              cmd_read,
  input  logic              cmd_ack,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ack_value,
  input  logic [DIV_W-1:0]  reload,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              busy,
  output logic              done,
  output logic              collision,
  output logic              ack_status,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CNT_W = $clog2(DATA_W + 2);

  op_e              sel, op;
  logic [1:0]       quarter;
  logic [CNT_W-1:0] bit_idx;
  logic             bit_low;
  lines_t           lines;
  logic             tick;
  logic [DATA_W-1:0] sh_value;
  logic             sh_next_msb;

  // Named internal events for the checker
  logic accept, q_end, sample_pt, last_bit, op_start_w, op_stop_w;
  logic first_low, next_low;

  i2cm_cmd_pick u_pick (
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_write(cmd_write),
    .cmd_read(cmd_read), .cmd_ack(cmd_ack), .sel(sel)
  );

  i2cm_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .reload(reload), .tick(tick)
  );

  assign accept    = !busy && (sel != OP_NONE);
  assign q_end     = busy && tick && (quarter == 2'd3);
  assign sample_pt = busy && tick && (quarter == 2'd1);
  assign last_bit  = (bit_idx == CNT_W'(op_bits(op, DATA_W) - 1));
  assign op_start_w = (op == OP_START);
  assign op_stop_w  = (op == OP_STOP);

  i2cm_shreg #(.W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n),
    .load(accept && sel == OP_WRITE), .load_val(wr_data),
    .shift((op == OP_WRITE && q_end) || (op == OP_READ && sample_pt)),
    .shift_in(sda_in), .value(sh_value), .next_msb(sh_next_msb)
  );

  // SDA level of the first bit of an accepted command
  always_comb begin
    case (sel)
      OP_WRITE: first_low = !wr_data[DATA_W-1];
      OP_ACK:   first_low = !ack_value;
      default:  first_low = 1'b0;
    endcase
  end

  // SDA level of the next bit within a write; released on the ack slot
  assign next_low = (op == OP_WRITE) && (bit_idx < CNT_W'(DATA_W - 1)) && !sh_next_msb;

  assign scl_drive_low = lines.scl_low;
  assign sda_drive_low = lines.sda_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      op         <= OP_NONE;
      quarter    <= 2'd0;
      bit_idx    <= '0;
      bit_low    <= 1'b0;
      lines      <= '0;
      done       <= 1'b0;
      collision  <= 1'b0;
      ack_status <= 1'b0;
      rd_data    <= '0;
    end else begin
      done      <= 1'b0;
      collision <= busy && cmd_write;
      if (accept) begin
        busy    <= 1'b1;
        op      <= sel;
        quarter <= 2'd0;
        bit_idx <= '0;
        bit_low <= first_low;
        lines   <= quarter_lines(sel, 2'd0, first_low);
      end else if (busy && tick) begin
        if (sample_pt && op == OP_WRITE && bit_idx == CNT_W'(DATA_W))
          ack_status <= sda_in;
        if (quarter == 2'd3) begin
          quarter <= 2'd0;
          if (last_bit) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (op == OP_READ) rd_data <= sh_value;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            bit_low <= next_low;
            lines   <= quarter_lines(op, 2'd0, next_low);
          end
        end else begin
          quarter <= quarter + 2'd1;
          lines   <= quarter_lines(op, quarter + 2'd1, bit_low);
        end
      end
    end
  end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       collision,
  input logic       scl_low,
  input logic       sda_low,
  input logic       tick,
  input logic [1:0] quarter,
  input logic       op_start_w,
  input logic       op_stop_w
);
  // Quarter index advances only on a divider tick (R2)
  assert_quarter_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (quarter != $past(quarter)) |-> $past(tick));

  // SDA falling with SCL released happens only in a start (R3)
  assert_start_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low) && !scl_low && !$past(scl_low)) |-> (busy && op_start_w));

  // SDA stable while SCL released except in start/stop (R4)
  assert_sda_stable_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && !$past(scl_low) && (sda_low != $past(sda_low)))
      |-> (busy && (op_start_w || op_stop_w)));

  // Stop leaves the bus idle (R8)
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_stop_w) |-> (!scl_low && !sda_low));

  // Completion flag is one cycle and follows busy (R9)
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // Collision only reported for a strobe during an operation (R10)
  assert_collision_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> $past(busy));
endmodule

bind i2c_byte_master i2cm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .collision(collision),
  .scl_low(scl_drive_low), .sda_low(sda_drive_low), .tick(tick),
  .quarter(quarter), .op_start_w(op_start_w), .op_stop_w(op_stop_w)
);

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, cmd_stop = 0, cmd_write = 0, cmd_read = 0, cmd_ack = 0;
  logic [7:0] wr_data = 8'h00;
  logic ack_value = 1'b0;
  logic [7:0] reload = 8'd2;
  logic slave_low = 1'b0;
  logic sda_in;
  logic scl_drive_low, sda_drive_low, busy, done, collision, ack_status;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign sda_in = ~(sda_drive_low | slave_low);

  i2c_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_write(cmd_write), .cmd_read(cmd_read), .cmd_ack(cmd_ack),
    .wr_data(wr_data), .ack_value(ack_value), .reload(reload), .sda_in(sda_in),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .busy(busy),
    .done(done), .collision(collision), .ack_status(ack_status), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Reference: expected {scl_low, sda_low} per quarter; kinds 1 start,2 stop,3 write,4 read,5 ack
  function automatic logic [1:0] ref_lines(int kind, int q, logic bit_low);
    if (kind == 1) return {q >= 2, q >= 1};
    if (kind == 2) return {q == 0, q < 2};
    return {(q == 0 || q == 3), bit_low};
  endfunction

  // Run one command and compare both drive outputs on every cycle
  task automatic do_op(input int kind, input logic [7:0] data, input logic ackv,
                       input logic [7:0] sl_byte, input logic sl_ack,
                       input int poke_at, input bit with_write, input string req);
    int nbits, cyc, bad;
    logic [1:0] got, exp;
    nbits = (kind == 3) ? 9 : (kind == 4) ? 8 : 1;
    cyc = 0; bad = 0;
    wr_data = data; ack_value = ackv;
    cmd_start = (kind == 1); cmd_stop = (kind == 2);
    cmd_write = (kind == 3) || with_write; cmd_read = (kind == 4); cmd_ack = (kind == 5);
    @(negedge clk);
    cmd_start = 0; cmd_stop = 0; cmd_write = 0; cmd_read = 0; cmd_ack = 0;
    for (int b = 0; b < nbits; b++) begin
      logic bl;
      if (kind == 3) bl = (b < 8) ? !data[7-b] : 1'b0;
      else if (kind == 5) bl = !ackv;
      else bl = 1'b0;
      for (int q = 0; q < 4; q++) begin
        for (int c = 0; c <= int'(reload); c++) begin
          if (q == 0 && c == 0) begin
            if (kind == 4) slave_low = !sl_byte[7-b];
            else if (kind == 3 && b == 8) slave_low = !sl_ack;
            else slave_low = 1'b0;
          end
          if (cyc == poke_at) begin cmd_write = 1; cmd_stop = 1; wr_data = 8'hFF; end
          if (poke_at >= 0 && cyc == poke_at + 1) begin
            cmd_write = 0; cmd_stop = 0;
            check(collision === 1'b1, "R10", "collision pulse", collision, 1);
          end
          got = {scl_drive_low, sda_drive_low};
          exp = ref_lines(kind, q, bl);
          if (got !== exp || busy !== 1'b1) begin
            if (bad == 0)
              $display("FAIL %s: lines at bit %0d quarter %0d got %b busy %b expected %b",
                       req, b, q, got, busy, exp);
            bad++;
          end
          cyc++;
          @(negedge clk);
        end
      end
    end
    slave_low = 1'b0;
    checks++;
    if (bad != 0) fails++;
    check(done === 1'b1 && busy === 1'b0, "R9", "done/busy at completion",
          {done, busy}, 2'b10);
    @(negedge clk);
    check(done === 1'b0, "R9", "done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({scl_drive_low, sda_drive_low, busy, done, collision, ack_status} === 6'b0 &&
          rd_data === 8'h00, "R1", "reset outputs",
          {scl_drive_low, sda_drive_low, busy, done, collision, ack_status, rd_data},
          0);
    rst_n = 1'b1;
    @(negedge clk);

    reload = 8'd2;
    do_op(1, 8'h00, 0, 8'h00, 0, -1, 0, "R3 R2");         // start
    do_op(3, 8'hA6, 0, 8'h00, 1, -1, 0, "R4 R2");         // address byte, slave NACK
    check(ack_status === 1'b1, "R5", "ack_status after NACK", ack_status, 1);
    do_op(3, 8'h3C, 0, 8'h00, 0, 20, 0, "R4 R10");        // data byte, write poked while busy
    check(ack_status === 1'b0, "R5", "ack_status after ACK", ack_status, 0);
    do_op(4, 8'h00, 0, 8'hC5, 0, -1, 0, "R6");
    check(rd_data === 8'hC5, "R6", "rd_data first read", rd_data, 8'hC5);
    do_op(5, 8'h00, 0, 8'h00, 0, -1, 0, "R7 ACK");
    do_op(4, 8'h00, 0, 8'h5A, 0, -1, 0, "R6");
    check(rd_data === 8'h5A, "R6", "rd_data second read", rd_data, 8'h5A);
    do_op(5, 8'h00, 1, 8'h00, 0, -1, 0, "R7 NACK");
    do_op(2, 8'h00, 0, 8'h00, 0, -1, 0, "R8");
    check(scl_drive_low === 1'b0 && sda_drive_low === 1'b0, "R8", "idle after stop",
          {scl_drive_low, sda_drive_low}, 0);

    // Fastest divider; start and write strobed together (R11)
    reload = 8'd0;
    repeat (2) @(negedge clk);
    do_op(1, 8'h00, 0, 8'h00, 0, -1, 1, "R11 R2");
    do_op(3, 8'h81, 0, 8'h00, 0, -1, 0, "R4 R2");
    check(ack_status === 1'b0, "R5", "ack_status fast write", ack_status, 0);
    do_op(2, 8'h00, 0, 8'h00, 0, -1, 0, "R8");
    check(rd_data === 8'h5A, "R10", "rd_data untouched by writes", rd_data, 8'h5A);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish got 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule